// File: doc/BRIEF.md
# Timer Time Base with Buffered Reload

This block is the counting core of a general-purpose timer. A prescaler divides an incoming count-enable pulse stream. The divided steps drive a counter that runs upward, downward, or up and down in turn. A repetition counter then thins the counter's wrap events into update events. The update events set a sticky flag, raise an interrupt line while that flag is set, and produce a one-cycle DMA request pulse.

The divide ratio, the wrap limit, the repetition count and a compare value are each written into a preload register. The active copies of these registers change only when an update event occurs. Software can therefore reprogram a running timer without tearing its period.

An update-generate pulse from software, or a reset pulse from a slave controller, restarts the counter and the prescaler and requests an update. Two control bits decide what such a request does. One bit keeps the flag quiet for requests that do not come from a wrap. The other bit blocks update events entirely.

Top module: `utb_timebase`

## Requirements
- R1: After reset the counter, update flag, interrupt, DMA request and every active copy read zero, and the counter direction reads up (cnt_dir = 0).
- R2: The counter moves one step for every act_psc+1 cycles in which cnt_tick is high. Cycles with cnt_tick low change neither the counter nor the prescaler.
- R3: Mode up (cfg_mode = 00): the counter counts upward and wraps from act_arr to 0. Starting from a restart, the first update event lands on the (PSC+1)·(ARR+1)·(RCR+1)-th tick.
- R4: Mode down (cfg_mode = 01): the counter counts downward and wraps from 0 to the reload value, which is the new limit when that wrap is also an update. The wrap is an update candidate.
- R5: Mode center (cfg_mode = 1x): the counter runs 0 up to act_arr and back down to 0. At each end it reverses; the step taken at the top and the step taken at the bottom are both update candidates. cnt_dir reads 1 while counting down.
- R6: An update event from wrapping occurs only on every (act_rcr+1)-th wrap. Wraps in between load nothing and set no flag.
- R7: Writes strobed by wr_psc, wr_arr, wr_rcr and wr_cmp reach only the preload registers. The active copies take the preload values at the clock edge of an update event.
- R8: A sw_ug pulse restarts the prescaler and the counter. The counter goes to 0, or to the reload value in mode down. The pulse also causes an update event that loads the active copies and sets the flag.
- R9: With cfg_urs = 1, an update requested by sw_ug or slv_rst still loads the active copies but leaves the flag and the DMA request untouched. Wrap-driven updates still set the flag.
- R10: With cfg_udis = 1, no update event occurs: the active copies hold and the flag stays clear. sw_ug still restarts the counter and the prescaler.
- R11: irq is high while the flag and cfg_uie are both 1. dma_req is a one-cycle pulse, in the cycle the flag is set, when cfg_ude = 1.
- R12: flag_clr clears the flag one edge later. A flag set in the same cycle takes precedence.
- R13: A slv_rst pulse acts exactly like sw_ug.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count-enable pulse into the prescaler |
| wr_psc | input | 1 | Write strobe, prescaler preload |
| wr_arr | input | 1 | Write strobe, wrap-limit preload |
| wr_rcr | input | 1 | Write strobe, repetition preload |
| wr_cmp | input | 1 | Write strobe, compare preload |
| wr_data | input | CNT_W | Write data shared by the strobes |
| cfg_mode | input | 2 | Counting mode: 00 up, 01 down, 1x center |
| cfg_urs | input | 1 | Flag only on wrap-driven updates |
| cfg_udis | input | 1 | Block update events |
| cfg_uie | input | 1 | Interrupt enable |
| cfg_ude | input | 1 | DMA request enable |
| sw_ug | input | 1 | Software update-generate pulse |
| slv_rst | input | 1 | Slave-controller reset pulse |
| flag_clr | input | 1 | Clear the update flag |
| cnt_val | output | CNT_W | Counter value |
| cnt_dir | output | 1 | Counting direction, 1 = down |
| uif | output | 1 | Sticky update flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request pulse |
| act_psc | output | CNT_W | Active prescaler value |
| act_arr | output | CNT_W | Active wrap limit |
| act_rcr | output | RCR_W | Active repetition count |
| act_cmp | output | CNT_W | Active compare value |

## Verification
A tick, a write strobe, a restart pulse or a clear takes effect at the first rising edge that samples it. From that edge on, the counter, the flag, the DMA pulse and the active copies show the new value. irq follows the flag and cfg_uie combinationally, with no extra delay. Every stimulus is applied on a falling edge and held for exactly the intended number of rising edges. Each result is read on the falling edge that follows the rising edge where it is due. The expected counts come from the tick number worked out from the divide ratio, the wrap limit and the repetition count.

// File: rtl/utb_pkg.sv
package utb_pkg;

  typedef enum logic [1:0] {
    MODE_UP   = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_CTR  = 2'b10,
    MODE_CTRB = 2'b11
  } cnt_mode_e;

  function automatic logic is_center(input cnt_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/utb_preload.sv
module utb_preload #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] pre_q,
  output logic [W-1:0] act_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_en) pre_q <= wr_data;
      if (load)  act_q <= pre_q;
    end
  end

endmodule

// File: rtl/utb_prescaler.sv
module utb_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reinit,
  input  logic [W-1:0] div,
  output logic         step
);

  logic [W-1:0] pcnt;
  logic         at_wrap;

  function automatic logic [W-1:0] f_next(input logic [W-1:0] v, input logic wrap);
    return wrap ? '0 : v + 1'b1;
  endfunction

  assign at_wrap = (pcnt >= div);
  assign step    = tick & at_wrap & ~reinit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (reinit)  pcnt <= '0;
    else if (tick)    pcnt <= f_next(pcnt, at_wrap);
  end

endmodule

// File: rtl/utb_counter.sv
module utb_counter
  import utb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         reinit,
  input  cnt_mode_e    mode,
  input  logic [W-1:0] arr_act,
  input  logic [W-1:0] arr_reload,
  output logic [W-1:0] cnt,
  output logic         dir_down,
  output logic         roll
);

  logic         at_end;
  logic [W-1:0] nxt;
  logic         nxt_dir;

  // value taken after turning at an end of the center-aligned sweep
  function automatic logic [W-1:0] f_bounce(input logic [W-1:0] lim, input logic from_top);
    if (lim == '0) return '0;
    return from_top ? lim - 1'b1 : {{(W-1){1'b0}}, 1'b1};
  endfunction

  // end detection depends only on the active limit
  always_comb begin
    case (mode)
      MODE_UP:   at_end = (cnt >= arr_act);
      MODE_DOWN: at_end = (cnt == '0);
      default:   at_end = dir_down ? (cnt == '0) : (cnt >= arr_act);
    endcase
  end

  assign roll = step & at_end;

  always_comb begin
    nxt_dir = (mode == MODE_DOWN);
    case (mode)
      MODE_UP:   nxt = at_end ? '0 : cnt + 1'b1;
      MODE_DOWN: nxt = at_end ? arr_reload : cnt - 1'b1;
      default: begin
        if (!dir_down) begin
          nxt     = at_end ? f_bounce(arr_reload, 1'b1) : cnt + 1'b1;
          nxt_dir = at_end;
        end else begin
          nxt     = at_end ? f_bounce(arr_reload, 1'b0) : cnt - 1'b1;
          nxt_dir = ~at_end;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_down <= 1'b0;
    end else if (reinit) begin
      cnt      <= (mode == MODE_DOWN) ? arr_reload : '0;
      dir_down <= (mode == MODE_DOWN);
    end else if (step) begin
      cnt      <= nxt;
      dir_down <= nxt_dir;
    end
  end

endmodule

// File: rtl/utb_repeat.sv
module utb_repeat #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         roll,
  input  logic         upd_evt,
  input  logic [W-1:0] rcr_act,
  input  logic [W-1:0] rcr_pre,
  output logic         hw_upd
);

  logic [W-1:0] rep;

  assign hw_upd = roll & (rep == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rep <= '0;
    else if (upd_evt)  rep <= rcr_pre;
    else if (roll)     rep <= (rep == '0) ? rcr_act : rep - 1'b1;
  end

endmodule

// File: rtl/utb_timebase.sv
module utb_timebase
  import utb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RCR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             wr_psc,
  input  logic             wr_arr,
  input  logic             wr_rcr,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_urs,
  input  logic             cfg_udis,
  input  logic             cfg_uie,
  input  logic             cfg_ude,
  input  logic             sw_ug,
  input  logic             slv_rst,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_dir,
  output logic             uif,
  output logic             irq,
  output logic             dma_req,
  output logic [CNT_W-1:0] act_psc,
  output logic [CNT_W-1:0] act_arr,
  output logic [RCR_W-1:0] act_rcr,
  output logic [CNT_W-1:0] act_cmp
);

  localparam int NWIDE   = 3;
  localparam int IDX_PSC = 0;
  localparam int IDX_ARR = 1;
  localparam int IDX_CMP = 2;

  cnt_mode_e                    mode;
  logic [NWIDE-1:0]             wide_wr;
  logic [NWIDE-1:0][CNT_W-1:0]  wide_pre;
  logic [NWIDE-1:0][CNT_W-1:0]  wide_act;
  logic [RCR_W-1:0]             rcr_pre;
  logic                         reinit;
  logic                         cnt_step;
  logic                         roll;
  logic                         hw_upd;
  logic                         upd_evt;
  logic                         flag_set;
  logic [CNT_W-1:0]             arr_reload;

  assign mode    = cnt_mode_e'(cfg_mode);
  assign wide_wr = {wr_cmp, wr_arr, wr_psc};

  // named events used by the logic and by the bound checker
  assign reinit     = sw_ug | slv_rst;
  assign upd_evt    = ~cfg_udis & (hw_upd | reinit);
  assign flag_set   = upd_evt & (~cfg_urs | hw_upd);
  assign arr_reload = upd_evt ? wide_pre[IDX_ARR] : wide_act[IDX_ARR];

  generate
    for (genvar gi = 0; gi < NWIDE; gi++) begin : g_wide
      utb_preload #(.W(CNT_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wide_wr[gi]),
        .wr_data (wr_data),
        .load    (upd_evt),
        .pre_q   (wide_pre[gi]),
        .act_q   (wide_act[gi])
      );
    end
  endgenerate

  utb_preload #(.W(RCR_W)) u_rcr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_rcr),
    .wr_data (wr_data[RCR_W-1:0]),
    .load    (upd_evt),
    .pre_q   (rcr_pre),
    .act_q   (act_rcr)
  );

  utb_prescaler #(.W(CNT_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (cnt_tick),
    .reinit (reinit),
    .div    (wide_act[IDX_PSC]),
    .step   (cnt_step)
  );

  utb_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (cnt_step),
    .reinit     (reinit),
    .mode       (mode),
    .arr_act    (wide_act[IDX_ARR]),
    .arr_reload (arr_reload),
    .cnt        (cnt_val),
    .dir_down   (cnt_dir),
    .roll       (roll)
  );

  utb_repeat #(.W(RCR_W)) u_rep (
    .clk     (clk),
    .rst_n   (rst_n),
    .roll    (roll),
    .upd_evt (upd_evt),
    .rcr_act (act_rcr),
    .rcr_pre (rcr_pre),
    .hw_upd  (hw_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uif     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      if (flag_set)      uif <= 1'b1;
      else if (flag_clr) uif <= 1'b0;
      dma_req <= flag_set & cfg_ude;
    end
  end

  assign irq     = uif & cfg_uie;
  assign act_psc = wide_act[IDX_PSC];
  assign act_arr = wide_act[IDX_ARR];
  assign act_cmp = wide_act[IDX_CMP];

endmodule

// File: rtl/utb_checker.sv
module utb_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_mode,
  input logic             cfg_urs,
  input logic             cfg_udis,
  input logic             sw_ug,
  input logic             slv_rst,
  input logic             flag_clr,
  input logic [CNT_W-1:0] cnt_val,
  input logic             uif,
  input logic             dma_req,
  input logic [CNT_W-1:0] act_arr,
  input logic [CNT_W-1:0] act_psc,
  input logic             cnt_step,
  input logic             roll,
  input logic             hw_upd,
  input logic             flag_set,
  input logic             reinit,
  input logic [CNT_W-1:0] arr_reload
);

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b00 && cnt_step && cnt_val >= act_arr && !reinit) |=> (cnt_val == '0)); // R3

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_val <= act_arr); // R5

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b01 && cnt_step && cnt_val == '0 && !reinit) |=> (cnt_val == $past(arr_reload))); // R4

  AST_REP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && !hw_upd && !reinit) |=> $stable(act_arr)); // R6

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_ug || slv_rst) && cfg_mode != 2'b01) |=> (cnt_val == '0)); // R8

  AST_URS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_urs && !hw_upd && !uif) |=> !uif); // R9

  AST_UDIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_udis |=> ($stable(act_arr) && $stable(act_psc))); // R10

  AST_DMA_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> uif); // R11

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !uif); // R12

endmodule

bind utb_timebase utb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_mode   (cfg_mode),
  .cfg_urs    (cfg_urs),
  .cfg_udis   (cfg_udis),
  .sw_ug      (sw_ug),
  .slv_rst    (slv_rst),
  .flag_clr   (flag_clr),
  .cnt_val    (cnt_val),
  .uif        (uif),
  .dma_req    (dma_req),
  .act_arr    (act_arr),
  .act_psc    (act_psc),
  .cnt_step   (cnt_step),
  .roll       (roll),
  .hw_upd     (hw_upd),
  .flag_set   (flag_set),
  .reinit     (reinit),
  .arr_reload (arr_reload)
);

// File: tb/utb_timebase_tb.sv
`timescale 1ns/1ps
module utb_timebase_tb;

  localparam int CNT_W = 16;
  localparam int RCR_W = 8;
  localparam logic [1:0] M_UP = 2'b00, M_DN = 2'b01, M_CT = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_tick = 0, wr_psc = 0, wr_arr = 0, wr_rcr = 0, wr_cmp = 0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_urs = 0, cfg_udis = 0, cfg_uie = 0, cfg_ude = 0;
  logic sw_ug = 0, slv_rst = 0, flag_clr = 0;
  logic [CNT_W-1:0] cnt_val, act_psc, act_arr, act_cmp;
  logic [RCR_W-1:0] act_rcr;
  logic cnt_dir, uif, irq, dma_req;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  utb_timebase #(.CNT_W(CNT_W), .RCR_W(RCR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
    .wr_psc(wr_psc), .wr_arr(wr_arr), .wr_rcr(wr_rcr), .wr_cmp(wr_cmp),
    .wr_data(wr_data), .cfg_mode(cfg_mode), .cfg_urs(cfg_urs),
    .cfg_udis(cfg_udis), .cfg_uie(cfg_uie), .cfg_ude(cfg_ude),
    .sw_ug(sw_ug), .slv_rst(slv_rst), .flag_clr(flag_clr),
    .cnt_val(cnt_val), .cnt_dir(cnt_dir), .uif(uif), .irq(irq),
    .dma_req(dma_req), .act_psc(act_psc), .act_arr(act_arr),
    .act_rcr(act_rcr), .act_cmp(act_cmp)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // all drivers change on a falling edge; each task starts and ends there
  task automatic wr_reg(input int sel, input int val);
    wr_data = CNT_W'(val);
    case (sel)
      0: wr_psc = 1;
      1: wr_arr = 1;
      2: wr_rcr = 1;
      default: wr_cmp = 1;
    endcase
    @(negedge clk);
    {wr_psc, wr_arr, wr_rcr, wr_cmp} = '0;
  endtask

  task automatic pulse_ug();
    sw_ug = 1; @(negedge clk); sw_ug = 0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  task automatic run(input int n);
    cnt_tick = 1;
    repeat (n) @(negedge clk);
    cnt_tick = 0;
  endtask

  task automatic setup(input logic [1:0] m, input int p, input int a, input int r);
    cfg_mode = m;
    wr_reg(0, p); wr_reg(1, a); wr_reg(2, r);
    pulse_ug();
    pulse_clr();
  endtask

  task automatic t_reset();
    chk("R1 cnt", cnt_val, 0);
    chk("R1 uif", uif, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma", dma_req, 0);
    chk("R1 act_arr", act_arr, 0);
    chk("R1 act_psc", act_psc, 0);
    chk("R1 dir", cnt_dir, 0);
  endtask

  task automatic t_prescale();
    setup(M_UP, 2, 9, 0);
    chk("R2 act_psc", act_psc, 2);
    run(2);  chk("R2 before step", cnt_val, 0);
    run(1);  chk("R2 first step", cnt_val, 1);
    repeat (5) @(negedge clk);
    chk("R2 tick low holds", cnt_val, 1);
    run(2);  chk("R2 prescaler held", cnt_val, 1);
    run(1);  chk("R2 second step", cnt_val, 2);
  endtask

  task automatic t_up_period();
    // (1+1)*(3+1)*(1+1) = 16 ticks to the first update
    setup(M_UP, 1, 3, 1);
    run(8);  chk("R6 first wrap cnt", cnt_val, 0);
    chk("R6 first wrap no flag", uif, 0);
    run(7);  chk("R3 tick 15 cnt", cnt_val, 3);
    chk("R3 tick 15 no flag", uif, 0);
    run(1);  chk("R3 tick 16 flag", uif, 1);
    chk("R3 tick 16 wrap", cnt_val, 0);
    pulse_clr();
  endtask

  task automatic t_down();
    setup(M_DN, 0, 4, 0);
    chk("R4 restart value", cnt_val, 4);
    chk("R4 dir", cnt_dir, 1);
    run(4);  chk("R4 at zero", cnt_val, 0);
    chk("R4 no flag yet", uif, 0);
    run(1);  chk("R4 underflow reload", cnt_val, 4);
    chk("R4 underflow flag", uif, 1);
    pulse_clr();
  endtask

  task automatic t_center();
    setup(M_CT, 0, 3, 0);
    run(3);  chk("R5 top value", cnt_val, 3);
    chk("R5 no flag at top", uif, 0);
    chk("R5 dir up", cnt_dir, 0);
    run(1);  chk("R5 turn down", cnt_val, 2);
    chk("R5 top flag", uif, 1);
    chk("R5 dir down", cnt_dir, 1);
    pulse_clr();
    run(2);  chk("R5 bottom value", cnt_val, 0);
    chk("R5 no flag at bottom", uif, 0);
    run(1);  chk("R5 turn up", cnt_val, 1);
    chk("R5 bottom flag", uif, 1);
    chk("R5 dir up again", cnt_dir, 0);
    pulse_clr();
  endtask

  task automatic t_preload();
    setup(M_UP, 0, 3, 0);
    run(2);  wr_reg(1, 6);
    chk("R7 active held", act_arr, 3);
    run(1);  chk("R7 old limit", cnt_val, 3);
    run(1);  chk("R7 wrap at old limit", cnt_val, 0);
    chk("R7 loaded on update", act_arr, 6);
    pulse_clr();
    run(6);  chk("R7 new limit reached", cnt_val, 6);
    chk("R7 no flag before wrap", uif, 0);
    run(1);  chk("R7 wrap at new limit", uif, 1);
    pulse_clr();
  endtask

  task automatic t_ug();
    setup(M_UP, 1, 7, 0);
    wr_reg(3, 42);
    chk("R7 cmp buffered", act_cmp, 0);
    run(5);  chk("R8 pre count", cnt_val, 2);
    wr_reg(0, 0);
    chk("R8 psc buffered", act_psc, 1);
    pulse_ug();
    chk("R8 counter restart", cnt_val, 0);
    chk("R8 flag", uif, 1);
    chk("R8 psc loaded", act_psc, 0);
    chk("R8 cmp loaded", act_cmp, 42);
    pulse_clr();
    run(1);  chk("R8 prescaler restarted", cnt_val, 1);
  endtask

  task automatic t_urs();
    setup(M_UP, 0, 2, 0);
    cfg_urs = 1;
    wr_reg(1, 5);
    pulse_ug();
    chk("R9 no flag on sw update", uif, 0);
    chk("R9 still loads", act_arr, 5);
    chk("R9 restart", cnt_val, 0);
    slv_rst = 1; @(negedge clk); slv_rst = 0;
    chk("R9 no flag on slave update", uif, 0);
    run(5);  chk("R9 before wrap", uif, 0);
    run(1);  chk("R9 wrap sets flag", uif, 1);
    cfg_urs = 0;
    pulse_clr();
  endtask

  task automatic t_udis();
    setup(M_UP, 0, 3, 0);
    run(2);
    cfg_udis = 1;
    wr_reg(1, 1);
    pulse_ug();
    chk("R10 restart still", cnt_val, 0);
    chk("R10 no flag", uif, 0);
    chk("R10 active held", act_arr, 3);
    run(4);  chk("R10 wrap value", cnt_val, 0);
    chk("R10 no flag on wrap", uif, 0);
    chk("R10 active held after wrap", act_arr, 3);
    cfg_udis = 0;
  endtask

  task automatic t_irq_dma();
    setup(M_UP, 0, 1, 0);
    cfg_uie = 1; cfg_ude = 1;
    run(1);  chk("R11 irq idle", irq, 0);
    chk("R11 dma idle", dma_req, 0);
    run(1);  chk("R11 irq on update", irq, 1);
    chk("R11 dma on update", dma_req, 1);
    @(negedge clk);
    chk("R11 dma one cycle", dma_req, 0);
    chk("R11 irq stays", irq, 1);
    cfg_uie = 0; #1;
    chk("R11 irq masked", irq, 0);
    cfg_ude = 0;
    @(negedge clk);
  endtask

  task automatic t_clear();
    chk("R12 flag set before clear", uif, 1);
    pulse_clr();
    chk("R12 cleared", uif, 0);
    setup(M_UP, 0, 0, 0);
    cnt_tick = 1; flag_clr = 1;
    @(negedge clk);
    cnt_tick = 0; flag_clr = 0;
    chk("R12 set wins over clear", uif, 1);
    pulse_clr();
    chk("R12 cleared again", uif, 0);
  endtask

  task automatic t_slave();
    setup(M_UP, 0, 7, 0);
    wr_reg(1, 5);
    run(3);  chk("R13 pre count", cnt_val, 3);
    slv_rst = 1; @(negedge clk); slv_rst = 0;
    chk("R13 restart", cnt_val, 0);
    chk("R13 flag", uif, 1);
    chk("R13 loads", act_arr, 5);
    pulse_clr();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_up_period();
    t_down();
    t_center();
    t_preload();
    t_ug();
    t_urs();
    t_udis();
    t_irq_dma();
    t_clear();
    t_slave();
    finish_run();
  end

endmodule